// File: doc/BRIEF.md
# Keyboard Matrix Row Scanner

This block walks a keyboard matrix of up to 16 rows by 8 columns on a slow scan clock. It reaches the matrix through 24 general-purpose pins. Two packed configuration vectors assign each pin at run time to a row role, a column role or no role. While a pass runs, the block pulls the pins of one row low at a time and leaves every other pin released. It then reads the column pins back, filters them for contact bounce and sends each accepted key as a one-cycle report of its row and column to a downstream queue.

A pass is started by holding the scan enable. Each pass begins with a fixed start delay and then visits every configured row in ascending index order. Each row gets a dwell of 16 cycles plus the programmed debounce count. A repeat gap closes the pass. If the enable is still high at the end of the pass, the next pass starts at once. Otherwise the scanner goes idle. Rows can be masked so that their keys produce no reports, although they are still scanned.

Top module: `keymatrix_scanner`

## Requirements
- R1: While reset is asserted and right after it, no pin is driven (pin_oe_o all zero) and key_valid_o is low.
- R2: Pin p takes its row field from row_cfg_i bits [32*(p/6)+5*(p%6) +: 5], where bit 0 set marks a row pin and bits 4:1 give the row index. It takes its column field from col_cfg_i bits [32*(p/8)+4*(p%8) +: 4], where bit 0 set marks a column pin and bits 3:1 give the column index. A pin that has both roles set acts only as a row. A pin with neither role is never driven, and its input is ignored.
- R3: At any cycle the driven pins (pin_oe_o bit 1, meaning pulled low) are exactly the pins whose row index equals one configured row, or no pin at all.
- R4: When scan_en_i is seen high by an idle scanner, the first row is driven 5 cycles later. A full pass lasts 5 + (16 + debounce_i) × (number of configured rows) + repeat_dly_i cycles, so passes that follow one another start their first row exactly that many cycles apart.
- R5: Within a pass, the configured rows are visited in ascending index order, each for 16 + debounce_i cycles. Row indices that no pin claims are skipped.
- R6: A column is accepted for the active row only if its level in dwell cycle 15 (counting from 0) matches its level in every later cycle of that dwell. A key that changes inside this window is not reported for that pass.
- R7: Accepted keys of a row are reported one per cycle, in ascending column order, starting in the cycle after the row's dwell ends. Each report is a single cycle with key_valid_o high, key_row_o = row index and key_col_o = column index.
- R8: A row whose row_mask_i bit is 1 is still scanned and timed, but none of its keys is reported.
- R9: A key held across passes is reported exactly once in each pass.
- R10: When scan_en_i is low at the end of a pass, the scanner finishes that pass and then drives no pin and makes no report until it is enabled again.
- R11: If no pin is configured as a row, a pass drives no pin and makes no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Run passes while high; sampled at the end of each pass |
| debounce_i | input | 10 | Extra dwell cycles per row (stability window) |
| repeat_dly_i | input | 16 | Gap in cycles at the end of each pass |
| row_cfg_i | input | 128 | Packed 5-bit row role fields, 6 per 32-bit word |
| col_cfg_i | input | 96 | Packed 4-bit column role fields, 8 per 32-bit word |
| row_mask_i | input | 16 | 1 = row produces no key reports |
| pin_in_i | input | 24 | Pin levels, low = key contact on a column pin |
| pin_oe_o | output | 24 | 1 = pull this pin low (active row) |
| key_valid_o | output | 1 | One-cycle key report strobe |
| key_row_o | output | 4 | Row index of the reported key |
| key_col_o | output | 3 | Column index of the reported key |

## Verification
The embedded properties assume that the pin configuration, the row masks and the debounce count stay constant while a pass runs. They also assume that pin levels arrive already synchronous to the scan clock. The row-order, present-row and mask-silence checks rely on these assumptions. The stimulus changes configuration, masks and timing values only while the scanner is idle, with margin after the last pass has ended. It drives every input on the falling clock edge. Bounce is produced only on a key whose toggle period is shorter than the stability window. The matrix model answers a driven row combinationally, so column levels depend only on settled drive state.

// File: rtl/keymatrix_pkg.sv
package keymatrix_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_START = 2'd1,
        SC_ROW   = 2'd2,
        SC_GAP   = 2'd3
    } scan_state_e;

    localparam int CFG_WORD_W = 32;

endpackage

// File: rtl/km_pin_map.sv
module km_pin_map
    import keymatrix_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ROWS     = 16,
    parameter int COLS     = 8,
    parameter int RIW      = 4,
    parameter int CIW      = 3,
    parameter int RWORDS   = 4,
    parameter int CWORDS   = 3
) (
    input  logic [RWORDS*CFG_WORD_W-1:0] row_cfg_i,
    input  logic [CWORDS*CFG_WORD_W-1:0] col_cfg_i,
    input  logic                         drive_active_i,
    input  logic [RIW-1:0]               cur_row_i,
    input  logic [NUM_PINS-1:0]          pin_in_i,
    output logic [NUM_PINS-1:0]          pin_oe_o,
    output logic [ROWS-1:0]              row_present_o,
    output logic [COLS-1:0]              col_now_o
);

    localparam int RFW = RIW + 1;
    localparam int CFW = CIW + 1;
    localparam int RPW = CFG_WORD_W / RFW;
    localparam int CPW = CFG_WORD_W / CFW;

    logic [NUM_PINS-1:0] is_row;
    logic [NUM_PINS-1:0] is_col;
    logic [RIW-1:0]      row_idx [NUM_PINS];
    logic [CIW-1:0]      col_idx [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int RB = (p / RPW) * CFG_WORD_W + (p % RPW) * RFW;
        localparam int CB = (p / CPW) * CFG_WORD_W + (p % CPW) * CFW;
        assign is_row[p]  = row_cfg_i[RB];
        assign row_idx[p] = row_cfg_i[RB+1 +: RIW];
        // a row role shadows a column role on the same pin
        assign is_col[p]  = col_cfg_i[CB] & ~row_cfg_i[RB];
        assign col_idx[p] = col_cfg_i[CB+1 +: CIW];
        assign pin_oe_o[p] = drive_active_i & is_row[p] & (row_idx[p] == cur_row_i);
    end

    always_comb begin
        row_present_o = '0;
        col_now_o     = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (is_row[p]) begin
                row_present_o[row_idx[p]] = 1'b1;
            end
            if (is_col[p] && !pin_in_i[p]) begin
                col_now_o[col_idx[p]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/km_row_seq.sv
module km_row_seq
    import keymatrix_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int RIW       = 4,
    parameter int DEB_W     = 10,
    parameter int RPT_W     = 16,
    parameter int CNT_W     = 17,
    parameter int START_DLY = 5,
    parameter int SETTLE    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en_i,
    input  logic [DEB_W-1:0] debounce_i,
    input  logic [RPT_W-1:0] repeat_dly_i,
    input  logic [ROWS-1:0]  row_present_i,
    output logic             drive_active_o,
    output logic [RIW-1:0]   cur_row_o,
    output logic [CNT_W-1:0] dwell_cnt_o,
    output logic             dwell_last_o
);

    typedef struct packed {
        scan_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [RIW-1:0]   row;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             has_first_d, has_next_d;
    logic [RIW-1:0]   first_row_d, next_row_d;
    logic [CNT_W-1:0] dwell_len_d, rpt_len_d;
    logic             dwell_end_d;

    always_comb begin
        has_first_d = 1'b0;
        has_next_d  = 1'b0;
        first_row_d = '0;
        next_row_d  = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (row_present_i[i]) begin
                has_first_d = 1'b1;
                first_row_d = RIW'(i);
                if (i > int'(seq_q.row)) begin
                    has_next_d = 1'b1;
                    next_row_d = RIW'(i);
                end
            end
        end

        dwell_len_d = CNT_W'(SETTLE) + CNT_W'(debounce_i);
        rpt_len_d   = CNT_W'(repeat_dly_i);
        dwell_end_d = (seq_q.st == SC_ROW) && (seq_q.cnt == dwell_len_d - CNT_W'(1));

        seq_d = seq_q;
        unique case (seq_q.st)
            SC_IDLE: begin
                if (scan_en_i) begin
                    seq_d.st  = SC_START;
                    seq_d.cnt = '0;
                end
            end
            SC_START: begin
                if (seq_q.cnt == CNT_W'(START_DLY - 1)) begin
                    seq_d.cnt = '0;
                    if (has_first_d) begin
                        seq_d.st  = SC_ROW;
                        seq_d.row = first_row_d;
                    end else if (rpt_len_d != '0) begin
                        seq_d.st = SC_GAP;
                    end else begin
                        seq_d.st = scan_en_i ? SC_START : SC_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            SC_ROW: begin
                if (dwell_end_d) begin
                    seq_d.cnt = '0;
                    if (has_next_d) begin
                        seq_d.row = next_row_d;
                    end else if (rpt_len_d != '0) begin
                        seq_d.st = SC_GAP;
                    end else begin
                        seq_d.st = scan_en_i ? SC_START : SC_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            SC_GAP: begin
                if (seq_q.cnt == rpt_len_d - CNT_W'(1)) begin
                    seq_d.cnt = '0;
                    seq_d.st  = scan_en_i ? SC_START : SC_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SC_IDLE, cnt: '0, row: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drive_active_o = (seq_q.st == SC_ROW);
    assign cur_row_o      = seq_q.row;
    assign dwell_cnt_o    = seq_q.cnt;
    assign dwell_last_o   = dwell_end_d;

    AST_START_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SC_START) |-> (seq_q.cnt < CNT_W'(START_DLY))); // R4

    AST_ROW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SC_ROW && $past(seq_q.st) == SC_START)
            |-> ($past(seq_q.cnt) == CNT_W'(START_DLY - 1))); // R4

    AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SC_ROW && $past(seq_q.st) == SC_ROW && !$past(dwell_end_d))
            |-> ($stable(seq_q.row) && seq_q.cnt == $past(seq_q.cnt) + CNT_W'(1))); // R5

    AST_ROW_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SC_ROW && $past(seq_q.st) == SC_ROW && $past(dwell_end_d))
            |-> (seq_q.row > $past(seq_q.row))); // R5

    AST_PRESENT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SC_ROW) |-> row_present_i[seq_q.row]); // R5

endmodule

// File: rtl/km_col_filter.sv
module km_col_filter #(
    parameter int COLS   = 8,
    parameter int RIW    = 4,
    parameter int CIW    = 3,
    parameter int CNT_W  = 17,
    parameter int SETTLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_active_i,
    input  logic [CNT_W-1:0] dwell_cnt_i,
    input  logic             dwell_last_i,
    input  logic [RIW-1:0]   cur_row_i,
    input  logic             row_masked_i,
    input  logic [COLS-1:0]  col_now_i,
    output logic             key_valid_o,
    output logic [RIW-1:0]   key_row_o,
    output logic [CIW-1:0]   key_col_o
);

    typedef struct packed {
        logic [COLS-1:0] ref_lvl;
        logic [COLS-1:0] chg;
        logic [COLS-1:0] pend;
        logic [RIW-1:0]  prow;
    } filt_t;

    filt_t f_d, f_q;

    logic            at_ref_d, in_win_d;
    logic [COLS-1:0] chg_all_d, base_d;

    always_comb begin
        at_ref_d  = row_active_i && (dwell_cnt_i == CNT_W'(SETTLE - 1));
        in_win_d  = row_active_i && (dwell_cnt_i >= CNT_W'(SETTLE));
        chg_all_d = in_win_d ? (f_q.chg | (col_now_i ^ f_q.ref_lvl)) : '0;
        base_d    = in_win_d ? f_q.ref_lvl : col_now_i;

        f_d = f_q;
        if (at_ref_d) begin
            f_d.ref_lvl = col_now_i;
            f_d.chg     = '0;
        end else if (in_win_d) begin
            f_d.chg = chg_all_d;
        end

        if (dwell_last_i) begin
            f_d.pend = row_masked_i ? '0 : (base_d & ~chg_all_d);
            f_d.prow = cur_row_i;
        end else begin
            // retire the lowest pending column
            f_d.pend = f_q.pend & (f_q.pend - COLS'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        key_col_o = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (f_q.pend[c]) begin
                key_col_o = CIW'(c);
            end
        end
    end

    assign key_valid_o = |f_q.pend;
    assign key_row_o   = f_q.prow;

    AST_EMPTY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_last_i |-> (f_q.pend == '0)); // R7

    AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|f_q.pend && !dwell_last_i)
            |=> ($countones(f_q.pend) == $past($countones(f_q.pend)) - 1)); // R7

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_last_i && row_masked_i) |=> (f_q.pend == '0)); // R8

endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
    import keymatrix_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int ROWS      = 16,
    parameter int COLS      = 8,
    parameter int DEB_W     = 10,
    parameter int RPT_W     = 16,
    parameter int START_DLY = 5,
    parameter int SETTLE    = 16,
    localparam int RIW      = $clog2(ROWS),
    localparam int CIW      = $clog2(COLS),
    localparam int RWORDS   = (NUM_PINS + CFG_WORD_W / (RIW + 1) - 1) / (CFG_WORD_W / (RIW + 1)),
    localparam int CWORDS   = (NUM_PINS + CFG_WORD_W / (CIW + 1) - 1) / (CFG_WORD_W / (CIW + 1))
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scan_en_i,
    input  logic [DEB_W-1:0]             debounce_i,
    input  logic [RPT_W-1:0]             repeat_dly_i,
    input  logic [RWORDS*CFG_WORD_W-1:0] row_cfg_i,
    input  logic [CWORDS*CFG_WORD_W-1:0] col_cfg_i,
    input  logic [ROWS-1:0]              row_mask_i,
    input  logic [NUM_PINS-1:0]          pin_in_i,
    output logic [NUM_PINS-1:0]          pin_oe_o,
    output logic                         key_valid_o,
    output logic [RIW-1:0]               key_row_o,
    output logic [CIW-1:0]               key_col_o
);

    localparam int CNT_W = ((RPT_W > DEB_W + 1) ? RPT_W : DEB_W + 1) + 1;

    logic             drive_active;
    logic [RIW-1:0]   cur_row;
    logic [CNT_W-1:0] dwell_cnt;
    logic             dwell_last;
    logic [ROWS-1:0]  row_present;
    logic [COLS-1:0]  col_now;

    km_pin_map #(
        .NUM_PINS(NUM_PINS), .ROWS(ROWS), .COLS(COLS),
        .RIW(RIW), .CIW(CIW), .RWORDS(RWORDS), .CWORDS(CWORDS)
    ) u_pin_map (
        .row_cfg_i      (row_cfg_i),
        .col_cfg_i      (col_cfg_i),
        .drive_active_i (drive_active),
        .cur_row_i      (cur_row),
        .pin_in_i       (pin_in_i),
        .pin_oe_o       (pin_oe_o),
        .row_present_o  (row_present),
        .col_now_o      (col_now)
    );

    km_row_seq #(
        .ROWS(ROWS), .RIW(RIW), .DEB_W(DEB_W), .RPT_W(RPT_W),
        .CNT_W(CNT_W), .START_DLY(START_DLY), .SETTLE(SETTLE)
    ) u_row_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .scan_en_i      (scan_en_i),
        .debounce_i     (debounce_i),
        .repeat_dly_i   (repeat_dly_i),
        .row_present_i  (row_present),
        .drive_active_o (drive_active),
        .cur_row_o      (cur_row),
        .dwell_cnt_o    (dwell_cnt),
        .dwell_last_o   (dwell_last)
    );

    km_col_filter #(
        .COLS(COLS), .RIW(RIW), .CIW(CIW), .CNT_W(CNT_W), .SETTLE(SETTLE)
    ) u_col_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_active_i (drive_active),
        .dwell_cnt_i  (dwell_cnt),
        .dwell_last_i (dwell_last),
        .cur_row_i    (cur_row),
        .row_masked_i (row_mask_i[cur_row]),
        .col_now_i    (col_now),
        .key_valid_o  (key_valid_o),
        .key_row_o    (key_row_o),
        .key_col_o    (key_col_o)
    );

    AST_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n)) |-> (pin_oe_o == '0 && !key_valid_o)); // R1

endmodule

// File: tb/keymatrix_scanner_bench.sv
module keymatrix_scanner_bench;

    localparam int NP = 24;
    localparam int NR = 16;
    localparam int NC = 8;
    localparam int WD_LIMIT = 20000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           scan_en;
    logic [9:0]     debounce;
    logic [15:0]    repeat_dly;
    logic [127:0]   row_cfg;
    logic [95:0]    col_cfg;
    logic [NR-1:0]  row_mask;
    logic [NP-1:0]  pin_in;
    logic [NP-1:0]  pin_oe;
    logic           key_valid;
    logic [3:0]     key_row;
    logic [2:0]     key_col;

    keymatrix_scanner u_keymatrix_scanner (
        .clk(clk), .rst_n(rst_n), .scan_en_i(scan_en), .debounce_i(debounce),
        .repeat_dly_i(repeat_dly), .row_cfg_i(row_cfg), .col_cfg_i(col_cfg),
        .row_mask_i(row_mask), .pin_in_i(pin_in), .pin_oe_o(pin_oe),
        .key_valid_o(key_valid), .key_row_o(key_row), .key_col_o(key_col)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int                    b_row_of_pin [NP];
    int                    b_col_of_pin [NP];
    logic [NR-1:0][NC-1:0] keys;
    logic [NR-1:0][NC-1:0] key_eff;
    logic                  bounce_on;
    logic                  bounce_bit;

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0] exp_q [$];
    int rise_cyc [64];
    int rise_n = 0;
    int rep_cyc [64];
    int rep_n = 0;
    int drive_cnt = 0;
    int r3_viol = 0;
    bit seen_bounce = 0;
    bit seen_masked = 0;
    bit prev_drive = 0;

    always_comb begin
        key_eff = keys;
        if (bounce_on) key_eff[3][2] = bounce_bit;
    end

    // matrix model: a column pin reads low when a driven row has that key closed
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            pin_in[p] = 1'b1;
            if (b_col_of_pin[p] >= 0 && b_row_of_pin[p] < 0) begin
                for (int q = 0; q < NP; q++) begin
                    if (pin_oe[q] && b_row_of_pin[q] >= 0 &&
                        key_eff[b_row_of_pin[q]][b_col_of_pin[p]]) begin
                        pin_in[p] = 1'b0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg();
        row_cfg = '0;
        col_cfg = '0;
        for (int p = 0; p < NP; p++) begin
            if (b_row_of_pin[p] >= 0)
                row_cfg[32*(p/6) + 5*(p%6) +: 5] = {4'(b_row_of_pin[p]), 1'b1};
            if (b_col_of_pin[p] >= 0)
                col_cfg[32*(p/8) + 4*(p%8) +: 4] = {3'(b_col_of_pin[p]), 1'b1};
        end
    endtask

    // driver: push the reports one pass should produce (R5 order, R7 columns)
    task automatic push_pass();
        for (int r = 0; r < NR; r++) begin
            bit present = 0;
            for (int p = 0; p < NP; p++) if (b_row_of_pin[p] == r) present = 1;
            if (present && !row_mask[r]) begin
                for (int c = 0; c < NC; c++) begin
                    bit readable = 0;
                    for (int p = 0; p < NP; p++)
                        if (b_col_of_pin[p] == c && b_row_of_pin[p] < 0) readable = 1;
                    if (readable && keys[r][c] && !(bounce_on && r == 3 && c == 2))
                        exp_q.push_back({4'(r), 3'(c)});
                end
            end
        end
    endtask

    task automatic monitor();
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (|pin_oe) begin
                    int r = -1;
                    drive_cnt++;
                    for (int q = 0; q < NP; q++)
                        if (pin_oe[q] && r < 0) r = b_row_of_pin[q];
                    if (r < 0) r3_viol++;
                    else
                        for (int q = 0; q < NP; q++)
                            if (pin_oe[q] != (b_row_of_pin[q] == r)) r3_viol++;
                    if (!prev_drive && rise_n < 64) begin
                        rise_cyc[rise_n] = cyc;
                        rise_n++;
                    end
                end
                prev_drive = |pin_oe;
                if (key_valid) begin
                    logic [6:0] got = {key_row, key_col};
                    if (rep_n < 64) rep_cyc[rep_n] = cyc;
                    rep_n++;
                    if (key_row == 4'd3 && key_col == 3'd2) seen_bounce = 1;
                    if (row_mask[key_row]) seen_masked = 1;
                    if (exp_q.size() == 0) begin
                        check(0, "R2,R5,R7", "unexpected report", int'(got), -1);
                    end else begin
                        logic [6:0] e = exp_q.pop_front();
                        check(got == e, "R2,R5,R7", "report row/col", int'(got), int'(e));
                    end
                end
            end
        end
    endtask

    task automatic watchdog();
        wait (cyc >= WD_LIMIT);
        check(0, "WDOG", "run did not finish", cyc, WD_LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic bouncer();
        int bcnt = 0;
        forever begin
            @(negedge clk);
            if (bounce_on) begin
                bcnt++;
                if (bcnt == 7) begin
                    bcnt = 0;
                    bounce_bit = ~bounce_bit;
                end
            end else begin
                bcnt = 0;
                bounce_bit = 1'b0;
            end
        end
    endtask

    initial begin
        int m, r0, p0, d0;
        rst_n = 1'b0;
        scan_en = 1'b0;
        debounce = '0;
        repeat_dly = '0;
        row_mask = '0;
        keys = '0;
        bounce_on = 1'b0;
        bounce_bit = 1'b0;
        for (int p = 0; p < NP; p++) begin
            b_row_of_pin[p] = -1;
            b_col_of_pin[p] = -1;
        end
        apply_cfg();
        fork
            monitor();
            watchdog();
            bouncer();
        join_none

        repeat (3) @(negedge clk);
        check(pin_oe == '0, "R1", "pins driven in reset", int'(pin_oe), 0);
        check(!key_valid, "R1", "report in reset", int'(key_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_oe == '0 && !key_valid, "R1", "activity after reset", int'(pin_oe), 0);

        // ---- single pass: mapping, debounce, mask, timing
        b_row_of_pin[2] = 3;  b_row_of_pin[5] = 0;  b_row_of_pin[9] = 7;
        b_row_of_pin[13] = 1; b_row_of_pin[21] = 10;
        b_col_of_pin[16] = 0; b_col_of_pin[17] = 2; b_col_of_pin[18] = 5;
        b_col_of_pin[19] = 7; b_col_of_pin[21] = 4;  // pin 21: row wins (R2)
        apply_cfg();
        debounce = 10'd20;
        repeat_dly = 16'd3;
        row_mask = 16'h0080;                           // row 7 masked (R8)
        keys[0][2] = 1; keys[0][5] = 1; keys[3][7] = 1; keys[10][0] = 1;
        keys[1][4] = 1;                                 // column 4 unreadable (R2)
        keys[5][0] = 1;                                 // row 5 unconfigured (R2)
        keys[7][0] = 1;                                 // masked row (R8)
        bounce_on = 1'b1;                               // key 3,2 bounces (R6)
        push_pass();
        r0 = rise_n; p0 = rep_n;
        @(negedge clk);
        m = cyc;
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
        repeat (260) @(negedge clk);
        check(rise_n - r0 == 1, "R10", "passes after a pulse", rise_n - r0, 1);
        check(rise_cyc[r0] - m == 6, "R4", "start delay to first row", rise_cyc[r0] - m, 6);
        check(rep_cyc[p0] - m == 42, "R7", "first report cycle", rep_cyc[p0] - m, 42);
        check(rep_n - p0 == 4, "R2", "report count", rep_n - p0, 4);
        check(exp_q.size() == 0, "R7", "missing reports", exp_q.size(), 0);
        check(!seen_bounce, "R6", "bouncing key reported", int'(seen_bounce), 0);
        check(!seen_masked, "R8", "masked row reported", int'(seen_masked), 0);
        bounce_on = 1'b0;
        d0 = drive_cnt; p0 = rep_n;
        repeat (200) @(negedge clk);
        check(drive_cnt == d0, "R10", "drive after pass end", drive_cnt - d0, 0);
        check(rep_n == p0, "R10", "reports after pass end", rep_n - p0, 0);

        // ---- back-to-back passes: held keys, pass period
        keys = '0;
        keys[0][0] = 1; keys[1][7] = 1; keys[7][5] = 1;
        row_mask = '0;
        debounce = '0;
        repeat_dly = '0;
        push_pass();
        push_pass();
        r0 = rise_n; p0 = rep_n;
        @(negedge clk);
        m = cyc;
        scan_en = 1'b1;
        repeat (127) @(negedge clk);
        scan_en = 1'b0;
        repeat (200) @(negedge clk);
        check(rise_n - r0 == 2, "R10", "passes while enabled", rise_n - r0, 2);
        check(rise_cyc[r0] - m == 6, "R4", "start delay", rise_cyc[r0] - m, 6);
        check(rise_cyc[r0+1] - rise_cyc[r0] == 85, "R4", "pass period",
              rise_cyc[r0+1] - rise_cyc[r0], 85);
        check(rep_n - p0 == 6, "R9", "held key reports over two passes", rep_n - p0, 6);
        check(exp_q.size() == 0, "R9", "missing reports", exp_q.size(), 0);
        d0 = drive_cnt;
        repeat (150) @(negedge clk);
        check(drive_cnt == d0, "R10", "drive after disable", drive_cnt - d0, 0);

        // ---- no row pins at all
        for (int p = 0; p < NP; p++) b_row_of_pin[p] = -1;
        apply_cfg();
        d0 = drive_cnt; p0 = rep_n;
        @(negedge clk);
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
        repeat (100) @(negedge clk);
        check(drive_cnt == d0, "R11", "drive with no rows", drive_cnt - d0, 0);
        check(rep_n == p0, "R11", "reports with no rows", rep_n - p0, 0);

        check(r3_viol == 0, "R3", "drive pattern violations", r3_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule